// File: doc/BRIEF.md
# System Interrupt Router and Gate

This block collects thirty-two level-sensitive device interrupt lines into a pending word. It translates each line into a processor priority level through a fixed, irregular table and raises one external-interrupt request towards the processor. Each line that rises or falls also produces a one-cycle set or clear pulse on the priority-level bit that belongs to that line. The pulse is addressed to the processor currently chosen by software, so a separate per-processor pending bank can track the levels.

Software uses a small 32-bit register window. It can read the pending word, read the disable mask, and clear disable bits through an enable port. It can set disable bits through a disable port, and doing so also discards the matching pending bits. It can select the 4-bit target processor. A request reaches the processor only when the line is pending and not masked and the global mask bit is clear. The level must also be 15, which cannot be masked, or be above the processor's current priority while traps are enabled. When several lines qualify, the highest level is presented.

Top module: `sys_irq_router`

## Requirements
- R1: After reset the pending word is 0, the disable mask reads 0x004DFF80, the target reads 0, and the request, code and level-port outputs are all 0.
- R2: Line-to-level table: lines 0..5 map to 2,3,5,7,9,11. Line 7 maps to 14. Lines 8..13 map to 3,5,7,9,11,13. Lines 14 and 15 map to 12. Line 16 maps to 6, line 18 to 4, line 19 to 10, line 20 to 8, line 22 to 11 and line 28 to 15. Every other line has no level and never sets a pending bit. When a mapped line is seen rising, its pending bit (read at word offset 0) is set after the next clock edge. When it is seen falling, the bit is cleared. Bit 31 of the offset 0 read is always 0.
- R3: In the cycle after a mapped line's transition is sampled, `lvl_set_o` or `lvl_clr_o` carries a bit at that line's level index, and `lvl_cpu_o` carries the target that held before that edge. A clear pulse and a set pulse for the same level never appear together; the set wins.
- R4: A write to offset 2 clears the disable bits selected by `wdata & 0x804DFF80`. The disable mask reads at offset 1.
- R5: A write to offset 3 sets the disable bits selected by `wdata & 0x804DFF80` and clears the same pending bits. This holds even when the line rises in the same cycle.
- R6: Offset 4 writes `wdata[3:0]` as the target and reads it back zero-extended. Offsets 5..7 read 0. Writes to offsets 0, 1 and 5..7 change nothing.
- R7: `irq_req_o` is 1 exactly when all of these hold: some mapped line is pending with its disable bit clear; disable bit 31 is clear; and the highest such level is 15, or it exceeds `cpu_pil_i` while `cpu_trap_en_i` is 1. The request follows the registered state and the current processor inputs in the same cycle.
- R8: While a request is raised, `irq_code_o` equals 0x10 plus the highest qualifying level. Without a request it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Device interrupt lines, level-sensitive |
| cpu_pil_i | input | 4 | Processor's current interrupt priority level |
| cpu_trap_en_i | input | 1 | Processor trap-enable flag |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_req_o | output | 1 | External interrupt request |
| irq_code_o | output | 8 | External-interrupt tag plus level |
| lvl_set_o | output | 16 | Level bits to set in the target processor's pending word |
| lvl_clr_o | output | 16 | Level bits to clear in the target processor's pending word |
| lvl_cpu_o | output | 4 | Processor the level pulses address |

## Verification
Two collisions can occur in one cycle. The first is a disable write and the rising edge of a line it masks; the second is a target-select write and a line transition. The bench forces both in directed steps. It then judges the first by reading back the pending word, which must show the bit clear. It judges the second by checking that the level pulse carries the old target. Randomised traffic also lets two lines of the same level rise and fall together, and the bench checks that only the set pulse survives.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int NSRC   = 32;
    localparam int LVL_W  = 4;
    localparam int NLVL   = 1 << LVL_W;
    localparam int CPU_W  = 4;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    // bits a disable/enable write may touch, and the reset mask
    localparam logic [DATA_W-1:0] WR_MASK  = 32'h804D_FF80;
    localparam logic [DATA_W-1:0] DIS_INIT = 32'h004D_FF80;
    localparam int GLOBAL_BIT = 31;
    localparam logic [LVL_W-1:0] NMI_LVL = '1;
    localparam logic [3:0] EXT_TAG = 4'h1;

    typedef enum logic [ADDR_W-1:0] {
        OFF_PEND = 3'd0,
        OFF_MASK = 3'd1,
        OFF_EN   = 3'd2,
        OFF_DIS  = 3'd3,
        OFF_TGT  = 3'd4
    } reg_off_e;

    typedef struct packed {
        logic [NSRC-1:0]  pend;
        logic [DATA_W-1:0] dis;
        logic [CPU_W-1:0] tgt;
        logic [NSRC-1:0]  src;
        logic [NLVL-1:0]  lset;
        logic [NLVL-1:0]  lclr;
        logic [CPU_W-1:0] lcpu;
    } rtr_state_t;

    function automatic logic [LVL_W-1:0] src_level(input int unsigned idx);
        logic [LVL_W-1:0] l;
        case (idx)
            0:  l = 4'd2;
            1:  l = 4'd3;
            2:  l = 4'd5;
            3:  l = 4'd7;
            4:  l = 4'd9;
            5:  l = 4'd11;
            7:  l = 4'd14;
            8:  l = 4'd3;
            9:  l = 4'd5;
            10: l = 4'd7;
            11: l = 4'd9;
            12: l = 4'd11;
            13: l = 4'd13;
            14: l = 4'd12;
            15: l = 4'd12;
            16: l = 4'd6;
            18: l = 4'd4;
            19: l = 4'd10;
            20: l = 4'd8;
            22: l = 4'd11;
            28: l = 4'd15;
            default: l = 4'd0;
        endcase
        return l;
    endfunction

    function automatic logic [NSRC-1:0] mapped_mask();
        logic [NSRC-1:0] m;
        m = '0;
        for (int i = 0; i < NSRC; i++) m[i] = (src_level(i) != '0);
        return m;
    endfunction

    localparam logic [NSRC-1:0] MAPPED = mapped_mask();

endpackage

// File: rtl/sirq_lvl_map.sv
module sirq_lvl_map
    import sirq_pkg::*;
#(
    parameter int N_LINES = NSRC,
    parameter int N_LEVELS = NLVL
) (
    input  logic [N_LINES-1:0]  lines_i,
    output logic [N_LEVELS-1:0] lvl_mask_o
);

    logic [N_LEVELS-1:0] contrib [N_LINES];

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        localparam logic [LVL_W-1:0] LV = src_level(g);
        if (LV != '0) begin : g_mapped
            always_comb begin
                contrib[g] = '0;
                contrib[g][LV] = lines_i[g];
            end
        end else begin : g_unmapped
            assign contrib[g] = '0;
        end
    end

    always_comb begin
        lvl_mask_o = '0;
        for (int i = 0; i < N_LINES; i++) lvl_mask_o |= contrib[i];
    end

endmodule

// File: rtl/sirq_prio.sv
module sirq_prio #(
    parameter int N_LEVELS = 16,
    localparam int W = $clog2(N_LEVELS)
) (
    input  logic [N_LEVELS-1:0] mask_i,
    output logic [W-1:0]        top_o,
    output logic                any_o
);

    always_comb begin
        top_o = '0;
        any_o = 1'b0;
        for (int i = 1; i < N_LEVELS; i++) begin
            if (mask_i[i]) begin
                top_o = W'(i);
                any_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sys_irq_router.sv
module sys_irq_router
    import sirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [LVL_W-1:0]  cpu_pil_i,
    input  logic              cpu_trap_en_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_req_o,
    output logic [7:0]        irq_code_o,
    output logic [NLVL-1:0]   lvl_set_o,
    output logic [NLVL-1:0]   lvl_clr_o,
    output logic [CPU_W-1:0]  lvl_cpu_o
);

    rtr_state_t st_d, st_q;

    logic [NSRC-1:0]   rise, fall, qual;
    logic [NLVL-1:0]   rise_lv, fall_lv, qual_lv;
    logic [LVL_W-1:0]  top_lv;
    logic              top_any;
    logic [DATA_W-1:0] wmask;
    logic              wr_en, wr_dis, wr_tgt;

    // edge detection against the previous sample of the lines
    assign rise = src_i & ~st_q.src & MAPPED;
    assign fall = ~src_i & st_q.src & MAPPED;

    // qualifying sources for the request path
    assign qual = st_q.pend & ~st_q.dis[NSRC-1:0] & MAPPED
                & {NSRC{~st_q.dis[GLOBAL_BIT]}};

    sirq_lvl_map #(.N_LINES(NSRC), .N_LEVELS(NLVL)) u_map_rise (
        .lines_i    (rise),
        .lvl_mask_o (rise_lv)
    );

    sirq_lvl_map #(.N_LINES(NSRC), .N_LEVELS(NLVL)) u_map_fall (
        .lines_i    (fall),
        .lvl_mask_o (fall_lv)
    );

    sirq_lvl_map #(.N_LINES(NSRC), .N_LEVELS(NLVL)) u_map_qual (
        .lines_i    (qual),
        .lvl_mask_o (qual_lv)
    );

    sirq_prio #(.N_LEVELS(NLVL)) u_prio (
        .mask_i (qual_lv),
        .top_o  (top_lv),
        .any_o  (top_any)
    );

    // register write decode
    assign wmask  = reg_wdata_i & WR_MASK;
    assign wr_en  = reg_wr_i && (reg_addr_i == OFF_EN);
    assign wr_dis = reg_wr_i && (reg_addr_i == OFF_DIS);
    assign wr_tgt = reg_wr_i && (reg_addr_i == OFF_TGT);

    // next-state computation
    always_comb begin
        st_d = st_q;
        st_d.src  = src_i;

        st_d.pend = (st_q.pend | rise) & ~fall;
        if (wr_dis) begin
            st_d.dis  = st_q.dis | wmask;
            st_d.pend = st_d.pend & ~wmask[NSRC-1:0];
        end
        if (wr_en) begin
            st_d.dis = st_q.dis & ~wmask;
        end
        if (wr_tgt) begin
            st_d.tgt = reg_wdata_i[CPU_W-1:0];
        end

        // level pulses to the per-processor bank, routed with the old target
        st_d.lset = rise_lv;
        st_d.lclr = fall_lv & ~rise_lv;
        st_d.lcpu = st_q.tgt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.dis  <= DIS_INIT;
            st_q.tgt  <= '0;
            st_q.src  <= '0;
            st_q.lset <= '0;
            st_q.lclr <= '0;
            st_q.lcpu <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            OFF_PEND: begin
                reg_rdata_o = st_q.pend;
                reg_rdata_o[GLOBAL_BIT] = 1'b0;
            end
            OFF_MASK: reg_rdata_o = st_q.dis;
            OFF_TGT:  reg_rdata_o[CPU_W-1:0] = st_q.tgt;
            default:  reg_rdata_o = '0;
        endcase
    end

    // request gate
    always_comb begin
        irq_req_o  = top_any &&
                     ((top_lv == NMI_LVL) || (cpu_trap_en_i && (top_lv > cpu_pil_i)));
        irq_code_o = irq_req_o ? {EXT_TAG, top_lv} : 8'h00;
    end

    assign lvl_set_o = st_q.lset;
    assign lvl_clr_o = st_q.lclr;
    assign lvl_cpu_o = st_q.lcpu;

endmodule

// File: rtl/sirq_chk.sv
module sirq_chk
    import sirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   pend,
    input logic [DATA_W-1:0] dis,
    input logic [CPU_W-1:0]  tgt,
    input logic [LVL_W-1:0]  cpu_pil,
    input logic              cpu_trap_en,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_req,
    input logic [7:0]        irq_code,
    input logic [NLVL-1:0]   lvl_set,
    input logic [NLVL-1:0]   lvl_clr
);

    assert_unmapped_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~MAPPED) == '0);

    assert_rd_top_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_PEND) |-> !reg_rdata[GLOBAL_BIT]);

    assert_lvl_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl_set & lvl_clr) == '0) && !lvl_set[0] && !lvl_clr[0]);

    assert_dis_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_DIS) |=>
        ((pend & $past(reg_wdata[NSRC-1:0] & WR_MASK[NSRC-1:0])) == '0));

    assert_tgt_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_TGT) |=> (tgt == $past(reg_wdata[CPU_W-1:0])));

    assert_global_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !dis[GLOBAL_BIT]);

    assert_pil_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_code[3:0] != NMI_LVL) |-> (cpu_trap_en && irq_code[3:0] > cpu_pil));

    assert_code_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_code[7:4] == EXT_TAG && irq_code[3:0] != '0));

    assert_code_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_code == 8'h00));

endmodule

bind sys_irq_router sirq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend        (st_q.pend),
    .dis         (st_q.dis),
    .tgt         (st_q.tgt),
    .cpu_pil     (cpu_pil_i),
    .cpu_trap_en (cpu_trap_en_i),
    .reg_wr      (reg_wr_i),
    .reg_addr    (reg_addr_i),
    .reg_wdata   (reg_wdata_i),
    .reg_rdata   (reg_rdata_o),
    .irq_req     (irq_req_o),
    .irq_code    (irq_code_o),
    .lvl_set     (lvl_set_o),
    .lvl_clr     (lvl_clr_o)
);

// File: tb/sim_sys_irq_router.sv
module sim_sys_irq_router;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [3:0]  pil = '0;
    logic        trap = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        req;
    logic [7:0]  code;
    logic [15:0] lset, lclr;
    logic [3:0]  lcpu;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // model state
    logic [31:0] m_pend, m_dis, m_prev;
    logic [3:0]  m_tgt;

    always #(CLK_PERIOD/2) clk = ~clk;

    sys_irq_router u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .cpu_pil_i(pil), .cpu_trap_en_i(trap),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_req_o(req), .irq_code_o(code), .lvl_set_o(lset), .lvl_clr_o(lclr),
        .lvl_cpu_o(lcpu)
    );

    function automatic logic [3:0] b_lvl(input int i);
        logic [3:0] t [32] = '{4'd2, 4'd3, 4'd5, 4'd7, 4'd9, 4'd11, 4'd0, 4'd14,
                              4'd3, 4'd5, 4'd7, 4'd9, 4'd11, 4'd13, 4'd12, 4'd12,
                              4'd6, 4'd0, 4'd4, 4'd10, 4'd8, 4'd0, 4'd11, 4'd0,
                              4'd0, 4'd0, 4'd0, 4'd0, 4'd15, 4'd0, 4'd0, 4'd0};
        return t[i];
    endfunction

    function automatic logic [31:0] b_mapped();
        logic [31:0] m = '0;
        for (int i = 0; i < 32; i++) m[i] = (b_lvl(i) != 0);
        return m;
    endfunction

    function automatic logic [15:0] b_levels(input logic [31:0] v);
        logic [15:0] r = '0;
        for (int i = 0; i < 32; i++) if (v[i] && b_lvl(i) != 0) r[b_lvl(i)] = 1'b1;
        return r;
    endfunction

    function automatic logic [7:0] b_code(input logic [31:0] p, input logic [31:0] d,
                                          input logic [3:0] pl, input logic te);
        logic [15:0] q;
        int top = 0;
        if (d[31]) return 8'h00;
        q = b_levels(p & ~d);
        for (int i = 1; i < 16; i++) if (q[i]) top = i;
        if (top == 0) return 8'h00;
        if (top == 15 || (te && top > pl)) return 8'h10 + 8'(top);
        return 8'h00;
    endfunction

    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic read_chk();
        wr = 1'b0;
        addr = 3'd0; #1; check("R2 pending read", rdata, m_pend & 32'h7FFF_FFFF);
        addr = 3'd1; #1; check("R4/R5 mask read", rdata, m_dis);
        addr = 3'd4; #1; check("R6 target read", rdata, {28'd0, m_tgt});
        addr = 3'd5; #1; check("R6 unused offset read", rdata, 32'd0);
    endtask

    task automatic step(input logic [31:0] s, input logic [3:0] p, input logic te,
                        input logic w, input logic [2:0] a, input logic [31:0] wd);
        logic [31:0] rise, fall, wm;
        logic [15:0] e_set, e_clr;
        logic [3:0]  e_cpu;
        logic [7:0]  e_code;
        @(negedge clk);
        src = s; pil = p; trap = te; wr = w; addr = a; wdata = wd;
        @(posedge clk);
        rise  = s & ~m_prev & b_mapped();
        fall  = ~s & m_prev & b_mapped();
        e_set = b_levels(rise);
        e_clr = b_levels(fall) & ~e_set;
        e_cpu = m_tgt;
        m_pend = (m_pend | rise) & ~fall;
        wm = wd & 32'h804D_FF80;
        if (w && a == 3'd3) begin m_dis = m_dis | wm; m_pend = m_pend & ~wm; end
        if (w && a == 3'd2) m_dis = m_dis & ~wm;
        if (w && a == 3'd4) m_tgt = wd[3:0];
        m_prev = s;
        e_code = b_code(m_pend, m_dis, p, te);
        #1;
        check("R3 level set", {16'd0, lset}, {16'd0, e_set});
        check("R3 level clear", {16'd0, lclr}, {16'd0, e_clr});
        check("R3 level cpu", {28'd0, lcpu}, {28'd0, e_cpu});
        check("R7 request", {31'd0, req}, {31'd0, e_code != 8'h00});
        check("R8 code", {24'd0, code}, {24'd0, e_code});
        read_chk();
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] s;
        void'($urandom(32'd4711));
        m_pend = '0; m_dis = 32'h004D_FF80; m_prev = '0; m_tgt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 request idle", {31'd0, req}, 32'd0);
        check("R1 code idle", {24'd0, code}, 32'd0);
        check("R1 set idle", {16'd0, lset}, 32'd0);
        check("R1 clear idle", {16'd0, lclr}, 32'd0);
        addr = 3'd1; #1; check("R1 mask reset", rdata, 32'h004D_FF80);
        addr = 3'd0; #1; check("R1 pending reset", rdata, 32'd0);
        addr = 3'd4; #1; check("R1 target reset", rdata, 32'd0);

        // R4 enable everything writable
        step('0, 4'd0, 1'b1, 1'b1, 3'd2, 32'hFFFF_FFFF);
        // R2/R7 line 0 -> level 2 with low pil
        step(32'h1, 4'd0, 1'b1, 1'b0, 3'd0, 0);
        // R7 pil above level blocks
        step(32'h1, 4'd3, 1'b1, 1'b0, 3'd0, 0);
        // R7 traps off block a non-15 level
        step(32'h1, 4'd0, 1'b0, 1'b0, 3'd0, 0);
        // R7 line 28 level 15 passes with traps off and high pil
        step(32'h1000_0001, 4'd15, 1'b0, 1'b0, 3'd0, 0);
        // R7 global mask bit 31 blocks all
        step(32'h1000_0001, 4'd0, 1'b1, 1'b1, 3'd3, 32'h8000_0000);
        step(32'h1000_0001, 4'd0, 1'b1, 1'b1, 3'd2, 32'h8000_0000);
        // R2 lines without a level are ignored; falling edges clear
        step(32'hA0A2_0040, 4'd0, 1'b1, 1'b0, 3'd0, 0);
        step('0, 4'd0, 1'b1, 1'b0, 3'd0, 0);
        // R3 same level 3: line 1 falls while line 8 rises
        step(32'h0000_0002, 4'd0, 1'b1, 1'b0, 3'd0, 0);
        step(32'h0000_0100, 4'd0, 1'b1, 1'b0, 3'd0, 0);
        // R5 disable write in the cycle line 7 rises
        step(32'h0000_0180, 4'd0, 1'b1, 1'b1, 3'd3, 32'h0000_0080);
        // R3 target write in the same cycle a line rises: old target routed
        step(32'h0000_0181, 4'd0, 1'b1, 1'b1, 3'd4, 32'hFFFF_FFF9);
        step(32'h0000_0183, 4'd0, 1'b1, 1'b0, 3'd0, 0);
        // R6 writes to read-only / unused offsets change nothing
        step(32'h0000_0183, 4'd0, 1'b1, 1'b1, 3'd0, 32'hFFFF_FFFF);
        step(32'h0000_0183, 4'd0, 1'b1, 1'b1, 3'd1, 32'h0000_0000);
        step(32'h0000_0183, 4'd0, 1'b1, 1'b1, 3'd6, 32'hFFFF_FFFF);

        // random traffic
        s = 32'h0000_0183;
        for (int i = 0; i < 600; i++) begin
            logic [2:0] a;
            logic w;
            s = s ^ ($urandom() & $urandom() & $urandom());
            w = ($urandom_range(0, 3) == 0);
            a = 3'($urandom_range(0, 7));
            step(s, 4'($urandom()), 1'($urandom()), w, a,
                 ($urandom_range(0, 3) == 0) ? 32'h8000_0000 | $urandom() : $urandom() & 32'h7FFF_FFFF);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule